// File: doc/BRIEF.md
# Chunked Stride DMA Address Generator

This block turns one DMA transfer description into a stream of word-sized source and destination address pairs. The transfer is described by a start address for each side, a total byte count, a common chunk length and a signed skip for each side. The transfer is cut into pieces of the chunk length. Between two adjacent pieces, each side's address jumps by that side's own skip. A skip may be positive, negative, or negative with a magnitude larger than the chunk, in which case the pieces walk downward through memory. A chunk length of zero, or one not smaller than the total, gives a single contiguous run.

One address pair is presented per beat under a valid/ready handshake. Either side can be pinned to its start address by clearing its increment enable, which is useful for a peripheral data register. A single-cycle done pulse follows the final beat. A new transfer can only be loaded while the block is idle.

Top module: `stride_addr_gen`

## Requirements
- R1: After reset, busy, beat_valid and done are low.
- R2: With a chunk length of zero, beat n of a side with its increment enabled carries the start address plus n times BEAT_BYTES (4 by default). No skip is ever applied.
- R3: With a non-zero chunk length, the beat at byte offset k carries start + k + floor(k / chunk) * skip on each incrementing side. The skip is a signed two's-complement value. A single byte counter decides the chunk boundary, so both sides take their skip on the same beat.
- R4: A negative skip is added as a signed value. If its magnitude exceeds the chunk length, each later chunk starts below the previous one.
- R5: The final chunk may be shorter than the chunk length, and no skip follows it. The transfer has exactly size / BEAT_BYTES beats, and beat_last is high on the final beat only.
- R6: A side whose increment enable was low at start keeps its start address on every beat, with neither step nor skip. The other side is unaffected.
- R7: While beat_valid is high and beat_ready is low, beat_valid stays high and beat_src, beat_dst and beat_last hold their values.
- R8: done is high for exactly one cycle, on the cycle after the final beat is accepted. The block is idle on the following cycle.
- R9: A start pulse while busy is high, including the done cycle, has no effect on the running transfer or on the state after it.
- R10: A transfer of size zero produces no beats and raises done on the cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load a new transfer (accepted only when idle) |
| src_base | input | ADDR_W | Source start address |
| dst_base | input | ADDR_W | Destination start address |
| xfer_size | input | ADDR_W | Total bytes, multiple of BEAT_BYTES |
| chunk_len | input | ADDR_W | Chunk length in bytes, 0 = contiguous |
| src_skip | input | SKIP_W | Signed source gap between chunks |
| dst_skip | input | SKIP_W | Signed destination gap between chunks |
| src_inc_en | input | 1 | Source address advances when high |
| dst_inc_en | input | 1 | Destination address advances when high |
| busy | output | 1 | Transfer loaded and not yet back to idle |
| beat_valid | output | 1 | Address pair on beat_src/beat_dst is valid |
| beat_ready | input | 1 | Consumer takes the current pair |
| beat_src | output | ADDR_W | Source address of current beat |
| beat_dst | output | ADDR_W | Destination address of current beat |
| beat_last | output | 1 | Current beat is the final one |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
All outputs are registered. The first address pair appears one cycle after the start edge. Each following pair appears one cycle after the edge that accepts the previous one, and done appears one cycle after the final acceptance. The bench builds the expected address list from the offset formula before each transfer. It drives beat_ready and samples every output on the falling edge, so each check reads the value settled after the last rising edge. Each falling-edge comparison is one step of the reference walk: the head of the list is compared while the pair is unaccepted, popped when ready was high, and the done and idle phases are checked on the next two falling edges.

// File: rtl/stride_addr_gen.sv
module stride_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int SKIP_W     = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        src_base,
  input  logic [ADDR_W-1:0]        dst_base,
  input  logic [ADDR_W-1:0]        xfer_size,
  input  logic [ADDR_W-1:0]        chunk_len,
  input  logic signed [SKIP_W-1:0] src_skip,
  input  logic signed [SKIP_W-1:0] dst_skip,
  input  logic                     src_inc_en,
  input  logic                     dst_inc_en,
  output logic                     busy,
  output logic                     beat_valid,
  input  logic                     beat_ready,
  output logic [ADDR_W-1:0]        beat_src,
  output logic [ADDR_W-1:0]        beat_dst,
  output logic                     beat_last,
  output logic                     done
);
  localparam logic [ADDR_W-1:0] BEAT = ADDR_W'(BEAT_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t                     st_q;
  logic [ADDR_W-1:0]       src_q, dst_q, left_q, cnt_q, chunk_q;
  logic signed [SKIP_W-1:0] sskip_q, dskip_q;
  logic                    sinc_q, dinc_q;

  logic                    fire, final_beat, chunk_end;
  logic [ADDR_W-1:0]       src_step, dst_step;

  assign fire       = (st_q == S_RUN) && beat_ready;
  assign final_beat = (left_q == BEAT);
  assign chunk_end  = (chunk_q != '0) && (cnt_q + BEAT == chunk_q);

  assign src_step = !sinc_q ? '0 : chunk_end ? BEAT + ADDR_W'(sskip_q) : BEAT;
  assign dst_step = !dinc_q ? '0 : chunk_end ? BEAT + ADDR_W'(dskip_q) : BEAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      left_q  <= '0;
      cnt_q   <= '0;
      chunk_q <= '0;
      sskip_q <= '0;
      dskip_q <= '0;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          src_q   <= src_base;
          dst_q   <= dst_base;
          left_q  <= xfer_size;
          cnt_q   <= '0;
          chunk_q <= chunk_len;
          sskip_q <= src_skip;
          dskip_q <= dst_skip;
          sinc_q  <= src_inc_en;
          dinc_q  <= dst_inc_en;
          st_q    <= (xfer_size == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (fire) begin
          if (final_beat) begin
            st_q <= S_FIN;
          end else begin
            src_q  <= src_q + src_step;
            dst_q  <= dst_q + dst_step;
            left_q <= left_q - BEAT;
            cnt_q  <= chunk_end ? '0 : cnt_q + BEAT;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign beat_valid = (st_q == S_RUN);
  assign beat_src   = src_q;
  assign beat_dst   = dst_q;
  assign beat_last  = (st_q == S_RUN) && final_beat;
  assign done       = (st_q == S_FIN);
endmodule

// File: rtl/stride_addr_gen_chk.sv
module stride_addr_gen_chk #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] xfer_size,
  input logic              busy,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_src,
  input logic [ADDR_W-1:0] beat_dst,
  input logic              beat_last,
  input logic              done,
  input logic [ADDR_W-1:0] chunk_q,
  input logic              sinc_q,
  input logic              dinc_q
);
  localparam logic [ADDR_W-1:0] BEAT = ADDR_W'(BEAT_BYTES);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !beat_valid && !done); // R1

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last && sinc_q && chunk_q == '0
    |=> beat_src == $past(beat_src) + BEAT); // R2

  AST_SRC_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last && !sinc_q |=> $stable(beat_src)); // R6

  AST_DST_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last && !dinc_q |=> $stable(beat_dst)); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready
    |=> beat_valid && $stable(beat_src) && $stable(beat_dst) && $stable(beat_last)); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> done && !beat_valid); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R8

  AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && xfer_size == '0 |=> done && !beat_valid); // R10
endmodule

bind stride_addr_gen stride_addr_gen_chk #(
  .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .xfer_size(xfer_size),
  .busy(busy), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .beat_src(beat_src), .beat_dst(beat_dst), .beat_last(beat_last),
  .done(done), .chunk_q(chunk_q), .sinc_q(sinc_q), .dinc_q(dinc_q)
);

// File: tb/stride_addr_gen_tb.sv
`timescale 1ns/1ps
module stride_addr_gen_tb;
  localparam int BB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0, xfer_size = '0, chunk_len = '0;
  logic signed [31:0] src_skip = '0, dst_skip = '0;
  logic src_inc_en = 1'b0, dst_inc_en = 1'b0, beat_ready = 1'b0;
  logic busy, beat_valid, beat_last, done;
  logic [31:0] beat_src, beat_dst;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  stride_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
    .dst_base(dst_base), .xfer_size(xfer_size), .chunk_len(chunk_len),
    .src_skip(src_skip), .dst_skip(dst_skip), .src_inc_en(src_inc_en),
    .dst_inc_en(dst_inc_en), .busy(busy), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_src(beat_src), .beat_dst(beat_dst),
    .beat_last(beat_last), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_addr(input logic [31:0] base, input int k,
      input logic [31:0] chunk, input int skip, input bit inc);
    longint a;
    if (!inc) return base;
    a = longint'(base) + k;
    if (chunk != 0) a += longint'(k / int'(chunk)) * skip;
    return a[31:0];
  endfunction

  task automatic run_xfer(input string req, input logic [31:0] sb, input logic [31:0] db,
      input logic [31:0] size, input logic [31:0] chunk, input int ss, input int ds,
      input bit si, input bit di, input int rmode, input bit poke);
    logic [31:0] qs[$];
    logic [31:0] qd[$];
    int it;
    int nb;
    bit r;
    for (int k = 0; k < int'(size); k += BB) begin
      qs.push_back(model_addr(sb, k, chunk, ss, si));
      qd.push_back(model_addr(db, k, chunk, ds, di));
    end
    nb = 0;
    @(negedge clk);
    src_base = sb; dst_base = db; xfer_size = size; chunk_len = chunk;
    src_skip = ss; dst_skip = ds; src_inc_en = si; dst_inc_en = di;
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    it = 0;
    while (qs.size() > 0) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && it == 2) begin
        src_base = 32'hDEAD_0000; xfer_size = 32'd4; chunk_len = 0; start = 1'b1;
      end
      r = (rmode == 0) ? 1'b1 : ((it % 3) != 1);
      beat_ready = r;
      chk(req, "valid", {31'b0, beat_valid}, 32'd1);
      chk(req, "src", beat_src, qs[0]);
      chk(req, "dst", beat_dst, qd[0]);
      chk("R5", "last", {31'b0, beat_last}, {31'b0, qs.size() == 1});
      chk("R8", "done early", {31'b0, done}, 32'd0);
      if (r) begin
        void'(qs.pop_front()); void'(qd.pop_front()); nb++;
      end
      it++;
    end
    @(negedge clk);
    beat_ready = 1'b0;
    start = poke;
    chk(size == 0 ? "R10" : "R8", "done", {31'b0, done}, 32'd1);
    chk("R8", "valid at done", {31'b0, beat_valid}, 32'd0);
    chk("R5", "beats", nb, size / BB);
    @(negedge clk);
    start = 1'b0;
    chk("R8", "done pulse end", {31'b0, done}, 32'd0);
    chk(poke ? "R9" : "R8", "idle busy", {31'b0, busy}, 32'd0);
    chk(poke ? "R9" : "R8", "idle valid", {31'b0, beat_valid}, 32'd0);
  endtask

  initial begin
    #20;
    @(negedge clk);
    chk("R1", "busy", {31'b0, busy}, 32'd0);
    chk("R1", "valid", {31'b0, beat_valid}, 32'd0);
    chk("R1", "done", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after release", {31'b0, busy}, 32'd0);

    run_xfer("R2", 32'h1000, 32'h8000, 32, 0, 64, -64, 1, 1, 0, 0);
    run_xfer("R2", 32'h2000, 32'h3000, 32, 64, 100, 100, 1, 1, 1, 0);
    run_xfer("R3", 32'h4000, 32'h5000, 64, 16, 8, 16, 1, 1, 1, 0);
    run_xfer("R4", 32'h6000, 32'h7000, 40, 16, -32, -8, 1, 1, 0, 0);
    run_xfer("R4", 32'h0000_0010, 32'hFFFF_FFF0, 48, 8, -24, 40, 1, 1, 1, 0);
    run_xfer("R6", 32'h9000, 32'hA000, 36, 8, 4, 4, 0, 1, 1, 0);
    run_xfer("R6", 32'h9100, 32'hA100, 24, 8, -12, 12, 1, 0, 0, 0);
    run_xfer("R9", 32'hB000, 32'hC000, 32, 8, 8, 8, 1, 1, 1, 1);
    run_xfer("R10", 32'hD000, 32'hE000, 0, 8, 8, 8, 1, 1, 0, 0);
    run_xfer("R7", 32'hF000, 32'hF800, 28, 12, -4, 20, 1, 1, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule